// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a memory-copy engine. Software fills a source pointer, a destination pointer and a 32-bit control word. The channel then copies a set number of halfword or word units through a simple master port. Each unit is a read at the source followed by a write of the same data at the destination. Both pointers move after every unit, each by its own rule: up, down, held, or (destination only) up with a return to the programmed base on every repeat.

A transfer starts on the clock after it is armed, or it waits for one of three one-cycle strobes: frame blank, line blank or a special event. A repeat bit keeps the channel armed for the next frame-blank or line-blank strobe, so the same copy runs every frame or every line. When the last unit is written, the channel can raise a one-cycle interrupt. Arbitration between channels and the stalling of a processor are left to the system around the block.

Top module: `dma_channel`

## Requirements
- R1: After reset the port makes no request, `irq_o` is low, and all three registers read back as zero (select 0 = source, 1 = destination, 2 = control, 3 reads zero).
- R2: Control bits [CNT_W-1:0] give the number of units to copy. A value of zero means 2^CNT_W units. Bits above CNT_W up to bit 15 are not stored.
- R3: Each unit is a read at the source pointer followed by a write at the destination pointer. `mem_size_o` follows control bit 26 (0 = halfword, 1 = word). A halfword write carries the low 16 read bits with the upper half zero; a word write carries all 32 bits.
- R4: Control bits 22:21 set how the destination moves after each unit: 0 adds the unit size in bytes (2 or 4), 1 subtracts it, 2 leaves the pointer unchanged, 3 adds it like code 0.
- R5: Control bits 24:23 set how the source moves, with the same codes. Code 3 acts as code 0.
- R6: Control bits 29:28 select the start: 0 starts on the next cycle, 1 waits for `vblank_i`, 2 for `hblank_i`, 3 for `event_i`. While the channel waits, strobes of the other kinds have no effect.
- R7: When control bit 25 is set and the start code is 1 or 2, a finished transfer leaves bit 31 set, reloads the count and waits for the next strobe. The source pointer continues from where it stopped. With destination code 3, the destination pointer returns to the programmed destination register.
- R8: When a transfer finishes and R7 does not apply, control bit 31 reads back as zero.
- R9: If control bit 30 is set, `irq_o` is high for exactly the one cycle after the last write is accepted. If the bit is clear, `irq_o` stays low.
- R10: Only source address bits 27:0 and destination address bits 26:0 are kept. Higher bits that are written read back as zero, and a pointer wraps within its width.
- R11: Writing the control word with bit 31 clear stops any transfer at once, and no further requests are made. Writing it with bit 31 set arms a new transfer from the current pointer registers.
- R12: A request holds its address and direction steady until `mem_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Readback of the selected register |
| vblank_i | input | 1 | Frame-blank start strobe |
| hblank_i | input | 1 | Line-blank start strobe |
| event_i | input | 1 | Special start strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_size_o | output | 1 | 1 = word, 0 = halfword |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid when a read is accepted |
| mem_ready_i | input | 1 | Accepts the current request |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The bench targets the points where a wrong channel would still look busy and plausible:
- A zero count taken literally would copy nothing instead of the maximum.
- A source code of 3 treated as "hold" or "reload" would stall the source pointer.
- A repeating channel that reloaded the source, or failed to return the destination, would copy the wrong block on the second strobe.
- A waiting channel that woke on the wrong strobe would start early.

It also aims random ready stalls at the read-to-write handoff. It checks that an abort during a stall stops all traffic. It checks that pointers near the top of their narrow widths wrap instead of carrying into bits that are not kept.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {ADJ_INC = 2'd0, ADJ_DEC = 2'd1, ADJ_FIX = 2'd2, ADJ_RLD = 2'd3} adj_e;
  typedef enum logic [1:0] {ST_NOW = 2'd0, ST_VBL = 2'd1, ST_HBL = 2'd2, ST_EVT = 2'd3} start_e;
  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_WAIT = 2'd1, SQ_RD = 2'd2, SQ_WR = 2'd3} seq_e;

  localparam int unsigned CB_DADJ  = 21;
  localparam int unsigned CB_SADJ  = 23;
  localparam int unsigned CB_RPT   = 25;
  localparam int unsigned CB_WORD  = 26;
  localparam int unsigned CB_START = 28;
  localparam int unsigned CB_IRQ   = 30;
  localparam int unsigned CB_EN    = 31;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef struct packed {
    logic   en;
    logic   irq;
    start_e start;
    logic   word;
    logic   rpt;
    adj_e   sadj;
    adj_e   dadj;
  } ctrl_s;

  function automatic logic [31:0] ctrl_encode(input ctrl_s c);
    logic [31:0] w;
    w = '0;
    w[CB_EN]          = c.en;
    w[CB_IRQ]         = c.irq;
    w[CB_START +: 2]  = c.start;
    w[CB_WORD]        = c.word;
    w[CB_RPT]         = c.rpt;
    w[CB_SADJ +: 2]   = c.sadj;
    w[CB_DADJ +: 2]   = c.dadj;
    return w;
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned SRC_AW = 28,
  parameter int unsigned DST_AW = 27,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  input  logic              clr_en_i,
  output logic [SRC_AW-1:0] src_base_o,
  output logic [DST_AW-1:0] dst_base_o,
  output ctrl_s             ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              arm_o,
  output logic              abort_o,
  output start_e            arm_start_o,
  output logic [CNT_W-1:0]  arm_count_o,
  output logic [31:0]       rdata_o
);

  logic [SRC_AW-1:0] src_q;
  logic [DST_AW-1:0] dst_q;
  ctrl_s             ctrl_q, wr_ctrl;
  logic [CNT_W-1:0]  count_q;
  logic              ctrl_wr;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr      = we_i && (sel_i == SEL_CTRL);

  always_comb begin
    wr_ctrl.en    = wdata_i[CB_EN];
    wr_ctrl.irq   = wdata_i[CB_IRQ];
    wr_ctrl.start = start_e'(wdata_i[CB_START +: 2]);
    wr_ctrl.word  = wdata_i[CB_WORD];
    wr_ctrl.rpt   = wdata_i[CB_RPT];
    wr_ctrl.sadj  = adj_e'(wdata_i[CB_SADJ +: 2]);
    wr_ctrl.dadj  = adj_e'(wdata_i[CB_DADJ +: 2]);
  end

  assign arm_o       = ctrl_wr && wr_ctrl.en;
  assign abort_o     = ctrl_wr && !wr_ctrl.en;
  assign arm_start_o = wr_ctrl.start;
  assign arm_count_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      ctrl_q  <= '0;
      count_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_SRC) src_q <= wdata_i[SRC_AW-1:0];
      if (we_i && sel_i == SEL_DST) dst_q <= wdata_i[DST_AW-1:0];
      if (ctrl_wr) begin
        ctrl_q  <= wr_ctrl;
        count_q <= wdata_i[CNT_W-1:0];
      end else if (clr_en_i) begin
        ctrl_q.en <= 1'b0;
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_SRC:  rdata_o = {{(32-SRC_AW){1'b0}}, src_q};
      SEL_DST:  rdata_o = {{(32-DST_AW){1'b0}}, dst_q};
      SEL_CTRL: rdata_o = ctrl_encode(ctrl_q) | {{(32-CNT_W){1'b0}}, count_q};
      default:  rdata_o = '0;
    endcase
  end

  assign src_base_o = src_q;
  assign dst_base_o = dst_q;
  assign ctrl_o     = ctrl_q;
  assign count_o    = count_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
#(
  parameter int unsigned AW        = 28,
  parameter bit          RELOAD_OK = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          reload_i,
  input  adj_e          adj_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q, addr_step, delta;
  logic          do_reload;

  assign delta = {{(AW-3){1'b0}}, word_i, ~word_i, 1'b0};

  always_comb begin
    case (adj_i)
      ADJ_DEC: addr_step = addr_q - delta;
      ADJ_FIX: addr_step = addr_q;
      default: addr_step = addr_q + delta;
    endcase
  end

  generate
    if (RELOAD_OK) begin : g_reload
      assign do_reload = reload_i && (adj_i == ADJ_RLD);
    end else begin : g_noreload
      // code 3 is plain increment here
      assign do_reload = reload_i & 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (load_i)    addr_q <= base_i;
    else if (do_reload) addr_q <= base_i;
    else if (step_i)    addr_q <= addr_step;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             abort_i,
  input  start_e           arm_start_i,
  input  logic [CNT_W-1:0] arm_count_i,
  input  ctrl_s            ctrl_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             vblank_i,
  input  logic             hblank_i,
  input  logic             event_i,
  input  logic             mem_ready_i,
  input  logic [31:0]      mem_rdata_i,
  output seq_e             state_o,
  output logic [31:0]      data_o,
  output logic             step_o,
  output logic             reload_o,
  output logic             clr_en_o,
  output logic             irq_o
);

  seq_e           st_q, st_d;
  logic [CNT_W:0] cnt_q, cnt_d;
  logic [31:0]    data_q;
  logic           irq_q, last, done, trig, rearm, hold;

  function automatic logic [CNT_W:0] full_cnt(input logic [CNT_W-1:0] c);
    return (c == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, c};
  endfunction

  always_comb begin
    case (ctrl_i.start)
      ST_VBL:  trig = vblank_i;
      ST_HBL:  trig = hblank_i;
      ST_EVT:  trig = event_i;
      default: trig = 1'b0;
    endcase
  end

  assign hold     = arm_i || abort_i;
  assign last     = (cnt_q == {{CNT_W{1'b0}}, 1'b1});
  assign rearm    = ctrl_i.rpt && (ctrl_i.start == ST_VBL || ctrl_i.start == ST_HBL);
  assign step_o   = (st_q == SQ_WR) && mem_ready_i && !hold;
  assign done     = step_o && last;
  assign reload_o = done && rearm;
  assign clr_en_o = done && !rearm;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (arm_i) begin
      cnt_d = full_cnt(arm_count_i);
      st_d  = (arm_start_i == ST_NOW) ? SQ_RD : SQ_WAIT;
    end else if (abort_i) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_WAIT: if (trig) st_d = SQ_RD;
        SQ_RD:   if (mem_ready_i) st_d = SQ_WR;
        SQ_WR: begin
          if (mem_ready_i) begin
            if (last) begin
              if (rearm) begin
                cnt_d = full_cnt(count_i);
                st_d  = SQ_WAIT;
              end else begin
                st_d = SQ_IDLE;
              end
            end else begin
              cnt_d = cnt_q - 1'b1;
              st_d  = SQ_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      irq_q <= done && ctrl_i.irq;
      if (st_q == SQ_RD && mem_ready_i && !hold)
        data_q <= ctrl_i.word ? mem_rdata_i : {16'h0000, mem_rdata_i[15:0]};
    end
  end

  assign state_o = st_q;
  assign data_o  = data_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned SRC_AW = 28,
  parameter int unsigned DST_AW = 27,
  parameter int unsigned CNT_W  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        vblank_i,
  input  logic        hblank_i,
  input  logic        event_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic        mem_size_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic        irq_o
);

  logic [SRC_AW-1:0] src_base, src_ptr;
  logic [DST_AW-1:0] dst_base, dst_ptr;
  ctrl_s             ctrl;
  logic [CNT_W-1:0]  count, arm_count;
  start_e            arm_start;
  seq_e              state;
  logic              arm, abort, clr_en, step, reload;

  dma_regs #(.SRC_AW(SRC_AW), .DST_AW(DST_AW), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .clr_en_i    (clr_en),
    .src_base_o  (src_base),
    .dst_base_o  (dst_base),
    .ctrl_o      (ctrl),
    .count_o     (count),
    .arm_o       (arm),
    .abort_o     (abort),
    .arm_start_o (arm_start),
    .arm_count_o (arm_count),
    .rdata_o     (reg_rdata_o)
  );

  dma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .abort_i     (abort),
    .arm_start_i (arm_start),
    .arm_count_i (arm_count),
    .ctrl_i      (ctrl),
    .count_i     (count),
    .vblank_i    (vblank_i),
    .hblank_i    (hblank_i),
    .event_i     (event_i),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (state),
    .data_o      (mem_wdata_o),
    .step_o      (step),
    .reload_o    (reload),
    .clr_en_o    (clr_en),
    .irq_o       (irq_o)
  );

  dma_addr_gen #(.AW(SRC_AW), .RELOAD_OK(1'b0)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (arm),
    .base_i   (src_base),
    .step_i   (step),
    .reload_i (reload),
    .adj_i    (ctrl.sadj),
    .word_i   (ctrl.word),
    .addr_o   (src_ptr)
  );

  dma_addr_gen #(.AW(DST_AW), .RELOAD_OK(1'b1)) u_dst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (arm),
    .base_i   (dst_base),
    .step_i   (step),
    .reload_i (reload),
    .adj_i    (ctrl.dadj),
    .word_i   (ctrl.word),
    .addr_o   (dst_ptr)
  );

  assign mem_req_o  = (state == SQ_RD) || (state == SQ_WR);
  assign mem_we_o   = (state == SQ_WR);
  assign mem_size_o = ctrl.word;
  assign mem_addr_o = (state == SQ_WR) ? {{(32-DST_AW){1'b0}}, dst_ptr}
                                       : {{(32-SRC_AW){1'b0}}, src_ptr};

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int unsigned SRC_AW = 28,
  parameter int unsigned DST_AW = 27
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_sel_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ready_i,
  input logic        irq_o
);

  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_sel_i == 2'd2);

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !ctrl_wr) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R3
  write_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ready_i));

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9
  irq_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));

  // R10
  src_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[31:SRC_AW] == '0));

  // R10
  dst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[31:DST_AW] == '0));

endmodule

bind dma_channel dma_channel_chk #(.SRC_AW(SRC_AW), .DST_AW(DST_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .irq_o       (irq_o)
);

// File: tb/tb_dma_channel.sv
module tb_dma_channel;

  localparam int unsigned CNT_W = 6;
  localparam logic [31:0] SMASK = 32'h0FFF_FFFF;
  localparam logic [31:0] DMASK = 32'h07FF_FFFF;
  localparam logic [31:0] CMASK = 32'hF7E0_0000 | ((32'd1 << CNT_W) - 32'd1);

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vblank = 1'b0, hblank = 1'b0, evt = 1'b0;
  logic        mem_req, mem_we, mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0] + 16'h0101};
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  dma_channel #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .vblank_i(vblank),
    .hblank_i(hblank), .event_i(evt), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_size_o(mem_size), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .irq_o(irq)
  );

  int checks = 0, errors = 0, wr_cnt = 0, irq_cnt = 0;
  string tag_req = "R12", tag_addr = "", tag_rd = "R10";
  logic [1:0] view_sel = 2'd2;
  bit rnd_rdy = 1'b0;

  // behavioural reference state: 0 idle, 1 waiting, 2 read, 3 write
  logic [31:0] m_src_r = '0, m_dst_r = '0, m_ctrl = '0;
  logic [31:0] m_sp = '0, m_dp = '0, m_data = '0;
  int          m_cnt = 0, m_st = 0;
  logic        m_irq = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic en, input logic ie, input logic [1:0] st,
                                     input logic wd, input logic rp, input logic [1:0] sa,
                                     input logic [1:0] da, input logic [15:0] n);
    return {en, ie, st, 1'b0, wd, rp, sa, da, 5'b0, n};
  endfunction

  function automatic int full_n();
    int n;
    n = int'(m_ctrl[CNT_W-1:0]);
    return (n == 0) ? (1 << CNT_W) : n;
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] p, input logic [1:0] code,
                                      input logic [31:0] msk);
    logic [31:0] sz;
    sz = m_ctrl[26] ? 32'd4 : 32'd2;
    case (code)
      2'd1:    return (p - sz) & msk;
      2'd2:    return p;
      default: return (p + sz) & msk;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return m_src_r;
      2'd1:    return m_dst_r;
      2'd2:    return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                     input logic v, input logic h, input logic s);
    logic rdy;
    logic [31:0] rv;
    int mode;
    bit exp_req;
    rdy = rnd_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
    reg_we = we; reg_sel = we ? sel : view_sel; reg_wdata = wd;
    vblank = v; hblank = h; evt = s; mem_ready = rdy;
    #1;
    exp_req = (m_st == 2 || m_st == 3);
    chk(mem_req == exp_req, tag_req, "req", {31'b0, mem_req}, {31'b0, exp_req});
    if (exp_req && mem_req) begin
      chk(mem_we == (m_st == 3), "R3", "we", {31'b0, mem_we}, {31'b0, m_st == 3});
      chk(mem_addr == ((m_st == 3) ? m_dp : m_sp),
          (tag_addr != "") ? tag_addr : ((m_st == 3) ? "R4" : "R5"), "addr",
          mem_addr, (m_st == 3) ? m_dp : m_sp);
      chk(mem_size == m_ctrl[26], "R3", "size", {31'b0, mem_size}, {31'b0, m_ctrl[26]});
      if (m_st == 3) chk(mem_wdata == m_data, "R3", "wdata", mem_wdata, m_data);
    end
    chk(irq == m_irq, "R9", "irq", {31'b0, irq}, {31'b0, m_irq});
    chk(reg_rdata == exp_rd(reg_sel), tag_rd, "rdata", reg_rdata, exp_rd(reg_sel));
    if (mem_req && mem_we && rdy) wr_cnt++;
    if (irq) irq_cnt++;
    // reference update for the coming edge
    m_irq = 1'b0;
    mode = int'(m_ctrl[29:28]);
    if (we && sel == 2'd2) begin
      m_ctrl = wd & CMASK;
      if (wd[31]) begin
        m_sp = m_src_r; m_dp = m_dst_r; m_cnt = full_n();
        m_st = (m_ctrl[29:28] == 2'd0) ? 2 : 1;
      end else begin
        m_st = 0;
      end
    end else begin
      case (m_st)
        1: if ((mode == 1 && v) || (mode == 2 && h) || (mode == 3 && s)) m_st = 2;
        2: if (rdy) begin
          rv = mem_fn(m_sp);
          m_data = m_ctrl[26] ? rv : {16'h0, rv[15:0]};
          m_st = 3;
        end
        3: if (rdy) begin
          m_sp = adv(m_sp, m_ctrl[24:23], SMASK);
          m_dp = adv(m_dp, m_ctrl[22:21], DMASK);
          if (m_cnt == 1) begin
            m_irq = m_ctrl[30];
            if (m_ctrl[25] && (mode == 1 || mode == 2)) begin
              m_cnt = full_n();
              if (m_ctrl[22:21] == 2'd3) m_dp = m_dst_r;
              m_st = 1;
            end else begin
              m_ctrl[31] = 1'b0;
              m_st = 0;
            end
          end else begin
            m_cnt = m_cnt - 1;
            m_st = 2;
          end
        end
        default: ;
      endcase
      if (we && sel == 2'd0) m_src_r = wd & SMASK;
      if (we && sel == 2'd1) m_dst_r = wd & DMASK;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    cyc(1'b1, sel, val, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && m_st >= 2; i++) idle(1);
    idle(2);
  endtask

  task automatic peek(input logic [1:0] s);
    reg_we = 1'b0; reg_sel = s;
    #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(2'd2);
    chk(mem_req == 1'b0, "R1", "req in reset", {31'b0, mem_req}, 32'h0);
    chk(irq == 1'b0, "R1", "irq in reset", {31'b0, irq}, 32'h0);
    chk(reg_rdata == 32'h0, "R1", "ctrl in reset", reg_rdata, 32'h0);
    peek(2'd0);
    chk(reg_rdata == 32'h0, "R1", "src in reset", reg_rdata, 32'h0);
    rst_ni = 1'b1;
    idle(2);

    // R3 R4 R5: immediate halfword, both increment, irq on
    wr(2'd0, 32'h0000_0100); wr(2'd1, 32'h0000_2000);
    wr_cnt = 0; irq_cnt = 0;
    wr(2'd2, mk(1, 1, 2'd0, 0, 0, 2'd0, 2'd0, 16'd4));
    drain();
    chk(wr_cnt == 4, "R2", "units copied", wr_cnt, 4);
    chk(irq_cnt == 1, "R9", "irq pulses", irq_cnt, 1);
    peek(2'd2);
    chk(reg_rdata[31] == 1'b0, "R8", "enable after done", {31'b0, reg_rdata[31]}, 32'h0);

    // word, dest decrement, source fixed, stalls
    rnd_rdy = 1'b1;
    wr(2'd0, 32'h0000_0400); wr(2'd1, 32'h0000_3000);
    wr_cnt = 0; irq_cnt = 0;
    wr(2'd2, mk(1, 1, 2'd0, 1, 0, 2'd2, 2'd1, 16'd3));
    drain();
    chk(wr_cnt == 3, "R4", "units word/dec", wr_cnt, 3);

    // R5: source code 3 steps like increment, no irq
    wr(2'd0, 32'h0000_0600); wr(2'd1, 32'h0000_4000);
    wr_cnt = 0; irq_cnt = 0;
    wr(2'd2, mk(1, 0, 2'd0, 1, 0, 2'd3, 2'd0, 16'd3));
    drain();
    chk(wr_cnt == 3, "R5", "units src code 3", wr_cnt, 3);
    chk(irq_cnt == 0, "R9", "irq disabled", irq_cnt, 0);

    // R6: frame-blank start ignores other strobes
    rnd_rdy = 1'b0;
    wr(2'd0, 32'h0000_0700); wr(2'd1, 32'h0000_4800);
    wr_cnt = 0; irq_cnt = 0;
    tag_req = "R6";
    wr(2'd2, mk(1, 1, 2'd1, 0, 0, 2'd1, 2'd2, 16'd2));
    idle(3);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    idle(3);
    chk(wr_cnt == 0, "R6", "no start on wrong strobe", wr_cnt, 0);
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0);
    drain();
    tag_req = "R12";
    chk(wr_cnt == 2, "R6", "units after frame strobe", wr_cnt, 2);

    // R7: line-blank repeat with destination reload
    wr(2'd0, 32'h0000_0800); wr(2'd1, 32'h0000_5000);
    wr_cnt = 0; irq_cnt = 0;
    tag_addr = "R7";
    wr(2'd2, mk(1, 1, 2'd2, 0, 1, 2'd0, 2'd3, 16'd3));
    idle(2);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
    drain();
    chk(wr_cnt == 3, "R7", "first pass", wr_cnt, 3);
    peek(2'd2);
    chk(reg_rdata[31] == 1'b1, "R7", "stays enabled", {31'b0, reg_rdata[31]}, 32'h1);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
    drain();
    chk(wr_cnt == 6, "R7", "second pass", wr_cnt, 6);
    chk(irq_cnt == 2, "R9", "irq per pass", irq_cnt, 2);
    tag_addr = "";

    // R11: abort mid-transfer under stalls
    rnd_rdy = 1'b1;
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
    idle(3);
    wr(2'd2, 32'h0);
    base = wr_cnt;
    tag_req = "R11";
    idle(8);
    tag_req = "R12";
    chk(wr_cnt == base, "R11", "no writes after abort", wr_cnt, base);
    rnd_rdy = 1'b0;

    // R2: count zero on special strobe
    wr(2'd0, 32'h0000_0010); wr(2'd1, 32'h0000_0100);
    wr_cnt = 0;
    wr(2'd2, mk(1, 1, 2'd3, 0, 0, 2'd0, 2'd0, 16'd0));
    idle(2);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    drain();
    chk(wr_cnt == (1 << CNT_W), "R2", "zero count", wr_cnt, 1 << CNT_W);

    // R10: kept widths and wrap
    wr(2'd0, 32'hFFFF_FFFC);
    peek(2'd0);
    chk(reg_rdata == 32'h0FFF_FFFC, "R10", "src width", reg_rdata, 32'h0FFF_FFFC);
    wr(2'd1, 32'hFFFF_FFFE);
    peek(2'd1);
    chk(reg_rdata == 32'h07FF_FFFE, "R10", "dst width", reg_rdata, 32'h07FF_FFFE);
    wr_cnt = 0;
    wr(2'd2, mk(1, 0, 2'd0, 0, 0, 2'd0, 2'd0, 16'd3));
    drain();
    chk(wr_cnt == 3, "R10", "units across wrap", wr_cnt, 3);

    summary();
    $finish;
  end

endmodule